// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block sits beside a small 8-bit CPU core and turns raw interrupt conditions into one request and a vector index for the core. It has two kinds of source. Event sources capture a one-cycle pulse in a sticky flag. The flag stays set until the core takes that vector or software clears it. Level sources have no flag and request service only while their input is high. Each source has an enable bit, and a global enable gates all of them. A fixed priority encoder picks the winner.

The core reports its own sequencing through strobes. A strobe marks the retirement of an instruction, of a set-global-enable, of a clear-global-enable and of a return-from-interrupt. The block uses these strobes to enforce two rules. After a set or a return, exactly one further instruction runs before any interrupt is taken. A clear takes effect in its own cycle. Saving the program counter and the status register is left to the core and to software.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_in[i]` sets flag i on the next edge. The flag stays set whatever the state of the source enable and of the global enable.
- R2: An `irq_ack` sampled while `irq_req` is high has two effects. It clears the event flag selected by `irq_vec`, and it clears the global enable, so `irq_req` is low in the next cycle. An `irq_ack` while `irq_req` is low changes nothing.
- R3: The register interface has two addresses. A write to address 0 loads the enable register, with bit i enabling source i. A write to address 1 clears every event flag whose data bit is 1 and leaves the rest unchanged. Level bits ignore writes to address 1. Reading address 0 returns the enables. Reading address 1 returns the event flags in the low N_EVT bits and the live level inputs above them.
- R4: An event and a clearing write to the same flag in the same cycle leave the flag set.
- R5: Event sources occupy indices 0 to N_EVT-1 and level sources the indices above them. `irq_vec` is the lowest index that is both pending and enabled, and it is 0 when no such index exists.
- R6: A level source is pending only while its input is high. A pulse that ends before the source is enabled leaves no request behind.
- R7: After a cycle with `sei` or `reti`, `irq_req` stays low until one `instr_retire` in a later cycle. This holds however many idle cycles pass. Both strobes set the global enable.
- R8: `irq_req` is low in any cycle with `cli` and in the cycle after it. This also holds for an event that arrives in the `cli` cycle. That event's flag is still kept.
- R9: After reset the enables, the flags and the global enable are 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | N_EVT | Event pulses, one per event source |
| lvl_in | input | N_LVL | Level conditions, one per level source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enables, 1 = flags |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | $clog2(N) | Index of the winning source |
| irq_ack | input | 1 | Core takes the vector |
| instr_retire | input | 1 | An instruction retired |
| sei | input | 1 | Set-global-enable retired |
| cli | input | 1 | Clear-global-enable retired |
| reti | input | 1 | Return-from-interrupt retired |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an event pulse on a flag and a clearing write to that same flag. The second pair is a clear-global-enable strobe and a fresh event. The bench drives each pair in a single low clock phase. It then judges the first pair by reading the flag register back, and the second by seeing `irq_req` low both in the `cli` cycle and after it while the flag still reads as set. A third case uses a hardware clear by acknowledge that is followed by a return. That case checks that the next request waits for exactly one retired instruction and then names the next flag in priority order.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_EVT = 6,
  parameter int N_LVL = 2,
  localparam int N  = N_EVT + N_LVL,
  localparam int VW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_LVL-1:0] lvl_in,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [N-1:0]     reg_wdata,
  output logic [N-1:0]     reg_rdata,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  input  logic             irq_ack,
  input  logic             instr_retire,
  input  logic             sei,
  input  logic             cli,
  input  logic             reti
);
  logic [N_EVT-1:0] flags, ack_clr, w1c;
  logic [N-1:0]     en, pend, hit;
  logic             gie, hold, take;

  assign pend      = {lvl_in, flags};
  assign hit       = pend & en;
  assign irq_req   = gie & ~hold & ~cli & (|hit);
  assign take      = irq_ack & irq_req;
  assign w1c       = (reg_we && reg_addr) ? reg_wdata[N_EVT-1:0] : '0;
  assign reg_rdata = reg_addr ? pend : en;

  always_comb begin
    irq_vec = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit[i]) irq_vec = VW'(i);
  end

  always_comb
    for (int i = 0; i < N_EVT; i++)
      ack_clr[i] = take && (irq_vec == VW'(i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      gie   <= 1'b0;
      hold  <= 1'b0;
    end else begin
      flags <= (flags & ~w1c & ~ack_clr) | evt_in;
      if (reg_we && !reg_addr) en <= reg_wdata;
      if (cli || take)     gie <= 1'b0;
      else if (sei || reti) gie <= 1'b1;
      if (sei || reti)        hold <= 1'b1;
      else if (instr_retire) hold <= 1'b0;
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_EVT = 6,
  parameter int N_LVL = 2,
  localparam int N  = N_EVT + N_LVL,
  localparam int VW = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [VW-1:0]    irq_vec,
  input logic             irq_ack,
  input logic             sei,
  input logic             cli,
  input logic             reti,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [N-1:0]     reg_wdata,
  input logic [N_EVT-1:0] evt_in,
  input logic [N_EVT-1:0] flags,
  input logic [N-1:0]     en,
  input logic [N-1:0]     pend
);
  logic [N-1:0] evt_w, flg_w, wd_clr;
  assign evt_w  = N'(evt_in);
  assign flg_w  = N'(flags);
  assign wd_clr = (reg_we && reg_addr) ? reg_wdata : '0;

  a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_w[0] && !wd_clr[0] && !(irq_ack && irq_req && irq_vec == '0)) |=> flg_w[0]);

  a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && int'(irq_vec) < N_EVT && !evt_w[irq_vec]) |=> !flg_w[$past(irq_vec)]);

  a_r2_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_w[0] && wd_clr[0]) |=> flg_w[0]);

  a_r5_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en[irq_vec] && pend[irq_vec]));

  a_r7_hold_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (sei || reti) |=> !irq_req);

  a_r8_cli_next: assert property (@(posedge clk) disable iff (!rst_n)
    cli |=> !irq_req);

  a_r8_cli_now: assert property (@(posedge clk) disable iff (!rst_n)
    cli |-> !irq_req);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_EVT(N_EVT), .N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .sei(sei), .cli(cli), .reti(reti),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt_in(evt_in), .flags(flags), .en(en), .pend(pend)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic [5:0] evt_in = 0;
  logic [1:0] lvl_in = 0;
  logic       reg_we = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack = 0, instr_retire = 0, sei = 0, cli = 0, reti = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  // {enable, event, level, exp req, exp vec}
  localparam logic [19:0] TBL [8] = '{
    {8'hFF, 6'h01, 2'b00, 1'b1, 3'd0},
    {8'hFF, 6'h28, 2'b00, 1'b1, 3'd3},
    {8'hF7, 6'h28, 2'b00, 1'b1, 3'd5},
    {8'h00, 6'h3F, 2'b00, 1'b0, 3'd0},
    {8'hC0, 6'h00, 2'b10, 1'b1, 3'd7},
    {8'hFF, 6'h20, 2'b01, 1'b1, 3'd5},
    {8'h40, 6'h3F, 2'b01, 1'b1, 3'd6},
    {8'hFF, 6'h00, 2'b00, 1'b0, 3'd0}
  };

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [5:0] m); evt_in = m; tick(); evt_in = 0; endtask
  task automatic do_sei();  sei = 1;  instr_retire = 1; tick(); sei = 0;  instr_retire = 0; endtask
  task automatic do_reti(); reti = 1; instr_retire = 1; tick(); reti = 0; instr_retire = 0; endtask
  task automatic do_cli();  cli = 1;  instr_retire = 1; tick(); cli = 0;  instr_retire = 0; endtask
  task automatic retire();  instr_retire = 1; tick(); instr_retire = 0; endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (2) tick();
    // R9 reset state
    chk("R9 req", 8'(irq_req), 8'd0);
    rd(0, d); chk("R9 enables", d, 8'h00);
    rd(1, d); chk("R9 flags", d, 8'h00);
    rst_n = 1; tick();

    // table walk: R5 priority, R6 levels, R7 hold after sei
    foreach (TBL[k]) begin
      wr(0, TBL[k][19:12]);
      lvl_in = TBL[k][5:4];
      pulse(TBL[k][11:6]);
      do_sei();
      chk("R7 hold after sei", 8'(irq_req), 8'd0);
      retire();
      chk("R5 req", 8'(irq_req), 8'(TBL[k][3]));
      chk("R5 vec", 8'(irq_vec), 8'(TBL[k][2:0]));
      do_cli(); wr(1, 8'hFF); lvl_in = 0;
    end

    // R1 masked event stays latched
    wr(0, 8'h00); do_sei(); retire();
    pulse(6'h04);
    rd(1, d); chk("R1 flag latched masked", d, 8'h04);
    chk("R1 no req masked", 8'(irq_req), 8'd0);
    wr(0, 8'h04);
    chk("R1 req once enabled", 8'(irq_req), 8'd1);
    chk("R1 vec", 8'(irq_vec), 8'd2);

    // R3 write-one-to-clear
    wr(1, 8'h00); rd(1, d); chk("R3 zero write keeps", d, 8'h04);
    wr(1, 8'hC4); rd(1, d); chk("R3 one write clears", d, 8'h00);
    wr(0, 8'hA5); rd(0, d); chk("R3 enable readback", d, 8'hA5);
    lvl_in = 2'b10; rd(1, d); chk("R3 level live readback", d, 8'h80); lvl_in = 0;

    // R4 set beats clear
    do_cli();
    reg_we = 1; reg_addr = 1; reg_wdata = 8'h02; evt_in = 6'h02; tick();
    reg_we = 0; evt_in = 0;
    rd(1, d); chk("R4 set wins", d, 8'h02);

    // R2 ack clears flag and gie; R7 one instruction after reti
    wr(0, 8'hFF); pulse(6'h01);
    do_sei(); retire();
    chk("R2 vec before ack", 8'(irq_vec), 8'd0);
    irq_ack = 1; tick(); irq_ack = 0;
    rd(1, d); chk("R2 flag cleared by ack", d, 8'h02);
    chk("R2 req low after ack", 8'(irq_req), 8'd0);
    do_reti();
    chk("R7 hold after reti", 8'(irq_req), 8'd0);
    repeat (3) tick();
    chk("R7 hold through idle", 8'(irq_req), 8'd0);
    retire();
    chk("R7 req after one instr", 8'(irq_req), 8'd1);
    chk("R7 vec next priority", 8'(irq_vec), 8'd1);

    // R8 cli blocks now and next, flag kept
    cli = 1; instr_retire = 1; evt_in = 6'h01; #1;
    chk("R8 req low in cli cycle", 8'(irq_req), 8'd0);
    tick(); cli = 0; instr_retire = 0; evt_in = 0;
    chk("R8 req low after cli", 8'(irq_req), 8'd0);
    rd(1, d); chk("R8 flag kept", d, 8'h03);

    // R2 ack without req ignored
    irq_ack = 1; tick(); irq_ack = 0;
    rd(1, d); chk("R2 stray ack no effect", d, 8'h03);

    // R6 level pulse before enable leaves nothing
    wr(1, 8'hFF); wr(0, 8'h00);
    lvl_in = 2'b01; tick(); lvl_in = 0;
    wr(0, 8'hFF); do_sei(); retire();
    chk("R6 vanished level", 8'(irq_req), 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule